// File: doc/BRIEF.md
# Timer flag and interrupt controller

This block is a modulo up-counter timer together with the status and interrupt logic around it. A 16-bit counter counts up to a programmable modulo value and then wraps. Each wrap raises an overflow flag. Four capture/compare channels each give the block a one-cycle event strobe, and each strobe raises that channel's flag. Every flag has its own enable bit. The enabled flags are OR-ed into one registered interrupt request line.

Software clears a flag in two steps. It first reads the flag register while the flag is set, which arms that flag. It then writes a 0 to the flag's bit. A debug break input freezes the counter. While a break lasts, a configuration bit decides whether register accesses may touch the flags at all; when they may not, a half-finished clear sequence is kept intact until the break ends. A power-mode input selects run, wait or stop. Wait changes nothing in the timer. Stop halts the counter and keeps every register.

Access is through a simple single-cycle register port with registered read data. Register addresses: 0 flags, 1 interrupt enables, 2 configuration, 3 modulo, 4 counter. Flag and enable bit positions are shared: bit 0 is overflow, and bit k+1 is channel k.

Top module: `tmr_flag_ctrl`

## Requirements
- R1: After reset all flags, all enables and the break clear-enable bit are 0, the modulo register is 0xFFFF, and irq_o and rdata_o are 0.
- R2: The counter advances by one per clock while counting is allowed. On the clock after it equals the modulo value, it becomes 0x0000 and flag bit 0 (overflow) becomes 1.
- R3: An event strobe on channel k sets flag bit k+1 on the next clock.
- R4: irq_o is registered. It is 1 one clock after any flag bit and the enable bit at the same position (register 1) are both 1, and 0 otherwise.
- R5: A read of register 0 arms every flag that is 1. A later write to register 0 clears each armed flag whose data bit is 0. Writing 1, or writing 0 to an unarmed flag, leaves the flag unchanged.
- R6: A setting event beats a clearing write in the same cycle, and it cancels any earlier arming, so a fresh read is needed before the next clear.
- R7: While brk_i is 1 the counter holds its value.
- R8: While brk_i is 1 and the clear-enable bit (register 2, bit 0) is 0, reads do not arm flags and writes do not clear them, and an arming made before the break survives it, so a write of 0 after the break clears the flag.
- R9: While the clear-enable bit is 1, the two-step clear works during a break, and a flag cleared there stays 0 after the break.
- R10: pwr_mode_i = 1 (wait) leaves counting and interrupts working. pwr_mode_i = 2 (stop) holds the counter while register contents are kept. Codes 0 and 3 count normally.
- R11: Register 1 holds the enables in bits 4:0, register 3 holds the modulo value, and register 4 returns the counter. Read data appears on rdata_o on the clock after the read cycle, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_i | input | 1 | Debug break: freezes counter, may block flag clearing |
| pwr_mode_i | input | 2 | 0 run, 1 wait, 2 stop, 3 run |
| evt_i | input | NUM_CH | Per-channel capture/compare event strobes |
| sel_i | input | 1 | Register access this cycle |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 3 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Three things can coincide with a flag in the same cycle: a channel strobe or counter wrap that sets the flag, a write that would clear it, and the break gating that blocks that write. The bench drives a strobe and a zero-write in one cycle, both for a flag that has just been armed and for a neighbour flag that was armed earlier. It then reads the flags back and expects the strobed flag to stay set and the neighbour to be cleared. It also places the read step and the write step on opposite sides of a break, and it judges from later reads whether the arming survived or was refused.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_IEN   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MOD   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CNT   = 3'd4;
  localparam logic [1:0] PWR_RUN  = 2'd0;
  localparam logic [1:0] PWR_WAIT = 2'd1;
  localparam logic [1:0] PWR_STOP = 2'd2;
endpackage

// File: rtl/tmr_modcount.sv
module tmr_modcount #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic hit;
  assign hit    = (cnt_o == mod_i);
  assign wrap_o = run_i && hit;

  always_ff @(posedge clk) begin
    if (rst)        cnt_o <= '0;
    else if (run_i) cnt_o <= hit ? '0 : cnt_o + W'(1);
  end
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic flag_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_i) begin
      flag_o  <= 1'b1;
      armed_q <= 1'b0;
    end else if (clr_i && armed_q) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (arm_i && flag_o) begin
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_flag_ctrl.sv
module tmr_flag_ctrl
  import tmr_flag_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              brk_i,
  input  logic [1:0]        pwr_mode_i,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int NFLAG = NUM_CH + 1;

  logic [NFLAG-1:0] ien_q;
  logic             clren_q;
  logic [CNT_W-1:0] mod_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_wrap;
  logic             run;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] flag_q;
  logic             access_ok;
  logic             rd_flags;
  logic             wr_flags;
  logic [CNT_W-1:0] rd_mux;

  assign run = !brk_i && (pwr_mode_i != PWR_STOP);

  tmr_modcount #(.W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .run_i(run), .mod_i(mod_q),
    .cnt_o(cnt_q), .wrap_o(cnt_wrap)
  );

  // status accesses are honoured outside a break, or inside one when allowed
  assign access_ok = !brk_i || clren_q;
  assign rd_flags  = sel_i && !we_i && (addr_i == ADDR_FLAGS) && access_ok;
  assign wr_flags  = sel_i &&  we_i && (addr_i == ADDR_FLAGS) && access_ok;
  assign set_vec   = {evt_i, cnt_wrap};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    tmr_flag_cell cell_i (
      .clk(clk), .rst(rst), .set_i(set_vec[g]),
      .arm_i(rd_flags), .clr_i(wr_flags && !wdata_i[g]),
      .flag_o(flag_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q   <= '0;
      clren_q <= 1'b0;
      mod_q   <= '1;
    end else if (sel_i && we_i) begin
      case (addr_i)
        ADDR_IEN: ien_q   <= wdata_i[NFLAG-1:0];
        ADDR_CFG: clren_q <= wdata_i[0];
        ADDR_MOD: mod_q   <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_FLAGS: rd_mux[NFLAG-1:0] = flag_q;
      ADDR_IEN:   rd_mux[NFLAG-1:0] = ien_q;
      ADDR_CFG:   rd_mux[0]         = clren_q;
      ADDR_MOD:   rd_mux            = mod_q;
      ADDR_CNT:   rd_mux            = cnt_q;
      default:    rd_mux            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (sel_i && !we_i) rdata_o <= rd_mux;
      irq_o <= |(flag_q & ien_q);
    end
  end
endmodule

// File: rtl/tmr_flag_chk.sv
module tmr_flag_chk
  import tmr_flag_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              brk_i,
  input logic [1:0]        pwr_mode_i,
  input logic [NUM_CH-1:0] evt_i,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  mod_q,
  input logic [NUM_CH:0]   flag_q,
  input logic [NUM_CH:0]   ien_q,
  input logic              clren_q,
  input logic              irq_o
);
  logic may_count;
  assign may_count = !brk_i && (pwr_mode_i != PWR_STOP);

  a_r2_wrap_sets_ovf: assert property (@(posedge clk) disable iff (rst)
    (may_count && cnt_q == mod_q) |=> (cnt_q == '0 && flag_q[0]));

  a_r3_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((flag_q[NUM_CH:1] & $past(evt_i)) == $past(evt_i)));

  a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(ien_q) != '0));

  a_r7_break_holds_count: assert property (@(posedge clk) disable iff (rst)
    brk_i |=> (cnt_q == $past(cnt_q)));

  a_r8_flags_kept_in_break: assert property (@(posedge clk) disable iff (rst)
    (brk_i && !clren_q) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  a_r10_stop_holds_count: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode_i == PWR_STOP) |=> (cnt_q == $past(cnt_q)));
endmodule

bind tmr_flag_ctrl tmr_flag_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst(rst), .brk_i(brk_i), .pwr_mode_i(pwr_mode_i),
  .evt_i(evt_i), .cnt_q(cnt_q), .mod_q(mod_q), .flag_q(flag_q),
  .ien_q(ien_q), .clren_q(clren_q), .irq_o(irq_o)
);

// File: tb/tmr_flag_ctrl_tb_top.sv
module tmr_flag_ctrl_tb_top;
  localparam int CNT_W = 16;
  localparam int NCH   = 4;
  localparam logic [1:0] OP_NONE = 2'd0;
  localparam logic [1:0] OP_RD   = 2'd1;
  localparam logic [1:0] OP_WR   = 2'd2;

  typedef struct packed {
    logic       brk;
    logic [3:0] evt;
    logic [1:0] op;
    logic [4:0] wd;
    logic [4:0] exp;
    logic [3:0] req;
  } vec_t;

  // flag bits: 0 overflow, k+1 channel k
  localparam int NVEC = 21;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 4'b0001, OP_NONE, 5'h00, 5'h00, 4'd3},  // R3 ch0 strobe
    '{1'b0, 4'b0000, OP_RD,   5'h00, 5'h02, 4'd3},
    '{1'b0, 4'b0000, OP_WR,   5'h00, 5'h00, 4'd5},  // R5 armed clear
    '{1'b0, 4'b0000, OP_RD,   5'h00, 5'h00, 4'd5},
    '{1'b0, 4'b0010, OP_NONE, 5'h00, 5'h00, 4'd3},  // ch1 strobe
    '{1'b0, 4'b0000, OP_WR,   5'h00, 5'h00, 4'd5},  // unarmed write
    '{1'b0, 4'b0000, OP_RD,   5'h00, 5'h04, 4'd5},
    '{1'b0, 4'b0000, OP_WR,   5'h1F, 5'h00, 4'd5},  // ones do nothing
    '{1'b0, 4'b0000, OP_RD,   5'h00, 5'h04, 4'd5},
    '{1'b1, 4'b0000, OP_WR,   5'h00, 5'h00, 4'd8},  // R8 gated write
    '{1'b1, 4'b0000, OP_RD,   5'h00, 5'h04, 4'd8},
    '{1'b0, 4'b0000, OP_WR,   5'h00, 5'h00, 4'd8},  // second step after break
    '{1'b0, 4'b0000, OP_RD,   5'h00, 5'h00, 4'd8},
    '{1'b0, 4'b0100, OP_NONE, 5'h00, 5'h00, 4'd3},  // ch2 strobe
    '{1'b1, 4'b0000, OP_RD,   5'h00, 5'h08, 4'd8},  // read in break: no arm
    '{1'b0, 4'b0000, OP_WR,   5'h00, 5'h00, 4'd8},
    '{1'b0, 4'b0000, OP_RD,   5'h00, 5'h08, 4'd8},
    '{1'b0, 4'b0100, OP_WR,   5'h00, 5'h00, 4'd6},  // R6 set beats clear
    '{1'b0, 4'b0000, OP_RD,   5'h00, 5'h08, 4'd6},
    '{1'b0, 4'b1000, OP_WR,   5'h00, 5'h00, 4'd6},  // ch2 cleared, ch3 set
    '{1'b0, 4'b0000, OP_RD,   5'h00, 5'h10, 4'd6}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             brk = 1'b0;
  logic [1:0]       pwr = 2'd0;
  logic [NCH-1:0]   evt = '0;
  logic             sel = 1'b0;
  logic             we  = 1'b0;
  logic [2:0]       addr = '0;
  logic [CNT_W-1:0] wdata = '0;
  logic [CNT_W-1:0] rdata;
  logic             irq;

  int checks = 0;
  int fails  = 0;
  logic [CNT_W-1:0] rv, c1, c2;

  always #10 clk = ~clk;

  tmr_flag_ctrl #(.CNT_W(CNT_W), .NUM_CH(NCH)) dut_i (
    .clk(clk), .rst(rst), .brk_i(brk), .pwr_mode_i(pwr), .evt_i(evt),
    .sel_i(sel), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [CNT_W-1:0] act,
                       input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [CNT_W-1:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
    rd(3'd0, rv); check("R1 flags", rv, 16'h0000);
    rd(3'd1, rv); check("R1 ien", rv, 16'h0000);
    rd(3'd2, rv); check("R1 cfg", rv, 16'h0000);
    rd(3'd3, rv); check("R1 mod", rv, 16'hFFFF);
    rd(3'd7, rv); check("R11 unmapped", rv, 16'h0000);

    pwr = 2'd2;  // stop: counter frozen for the table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      brk = VEC[i].brk;
      evt = VEC[i].evt;
      sel = (VEC[i].op != OP_NONE);
      we  = (VEC[i].op == OP_WR);
      addr = 3'd0;
      wdata = {11'd0, VEC[i].wd};
      @(negedge clk);
      evt = '0; sel = 1'b0; we = 1'b0;
      if (VEC[i].op == OP_RD)
        check($sformatf("R%0d step %0d", VEC[i].req, i), rdata, {11'd0, VEC[i].exp});
    end
    brk = 1'b0;

    // R9 clearing permitted during break (ch3 armed by last table read)
    wr(3'd2, 16'h0001);
    rd(3'd2, rv); check("R9 cfg readback", rv, 16'h0001);
    brk = 1'b1;
    wr(3'd0, 16'h0000);
    brk = 1'b0;
    rd(3'd0, rv); check("R9 cleared in break", rv, 16'h0000);
    @(negedge clk); evt = 4'b0001; @(negedge clk); evt = '0;
    brk = 1'b1;
    rd(3'd0, rv); check("R9 read in break", rv, 16'h0002);
    wr(3'd0, 16'h0000);
    brk = 1'b0;
    rd(3'd0, rv); check("R9 stays cleared", rv, 16'h0000);
    wr(3'd2, 16'h0000);

    // R4 interrupt gating
    @(negedge clk); evt = 4'b0010; @(negedge clk); evt = '0;
    @(negedge clk);
    check("R4 disabled no irq", {15'd0, irq}, 16'h0000);
    wr(3'd1, 16'h0004);
    @(negedge clk);
    check("R4 enabled irq", {15'd0, irq}, 16'h0001);
    rd(3'd1, rv); check("R11 ien readback", rv, 16'h0004);
    rd(3'd0, rv);
    wr(3'd0, 16'h0000);
    @(negedge clk);
    check("R4 irq drops", {15'd0, irq}, 16'h0000);

    // R10 stop keeps counter and registers
    rd(3'd4, c1); rd(3'd4, c2);
    check("R10 stop holds count", c2, c1);
    wr(3'd3, c1 + 16'd4);
    rd(3'd3, rv); check("R11 mod readback", rv, c1 + 16'd4);
    wr(3'd1, 16'h0001);

    // R2 wrap and overflow, counting in wait mode (R10)
    @(negedge clk); pwr = 2'd1;
    repeat (4) @(negedge clk);
    @(negedge clk);
    check("R10 wait irq not yet", {15'd0, irq}, 16'h0000);
    pwr = 2'd2;
    @(negedge clk);
    check("R10 wait irq raised", {15'd0, irq}, 16'h0001);
    rd(3'd4, rv); check("R2 wrapped to zero", rv, 16'h0000);
    rd(3'd0, rv); check("R2 overflow flag", rv, 16'h0001);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);

    // R2 counting and R7 break freeze
    wr(3'd3, 16'hFFFF);
    pwr = 2'd0;
    rd(3'd4, c1); rd(3'd4, c2);
    check("R2 advances", c2 - c1, 16'd2);
    @(negedge clk); brk = 1'b1;
    rd(3'd4, c1); rd(3'd4, c2);
    check("R7 break holds", c2 - c1, 16'd0);
    brk = 1'b0;
    pwr = 2'd1;
    rd(3'd4, c1); rd(3'd4, c2);
    check("R10 wait counts", c2 - c1, 16'd2);
    pwr = 2'd3;
    rd(3'd4, c1); rd(3'd4, c2);
    check("R10 code 3 counts", c2 - c1, 16'd2);

    finish_run();
  end
endmodule